// File: doc/BRIEF.md
# Second-Operand Shifter

This unit forms the second operand of a 32-bit data-processing or load/store instruction. It also forms the carry that the shifter hands to the flag logic. A neighbouring decoder gives it the low twelve bits of the instruction word, together with a bit that says whether the operand is an immediate. It also receives the value read for the shifted register, the low byte of the value read for the amount register, and the current carry flag. The unit returns the indices of those two registers so the register file can be addressed in the same cycle.

There are three operand forms. The first is an 8-bit constant rotated right by an even amount. The second is a register shifted by a 5-bit constant. The third is a register shifted by an amount held in another register. A zero constant amount in the second form has a special meaning that depends on the shift type. The third form takes an extra internal cycle, which the unit signals on an output. Results are registered and appear one clock after the inputs are applied.

Top module: `opsh_operand_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next values of `operand`, `carry_out`, `unshifted` and `extra_cycle` are all zero.
- R2: The form decode works as follows. With `imm_form`=1 the operand is an immediate. With `imm_form`=0 and `op_field[4]`=0, it is a register shifted by a constant. With `imm_form`=0 and `op_field[4]`=1, it is a register shifted by a register. In both shifted forms `op_field[6:5]` selects the shift: 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right. Every registered output reflects the inputs of the previous rising edge.
- R3: In immediate form, the operand is `op_field[7:0]` rotated right by twice `op_field[11:8]`. The carry is bit 31 of that result when the rotate amount is non-zero, and `carry_in` otherwise.
- R4: `rm_idx` equals `op_field[3:0]` and `rs_idx` equals `op_field[11:8]`, combinationally. In constant-shift form the amount is `op_field[11:7]`.
- R5: A constant left shift by 0 passes `rm_val` through, keeps `carry_in`, and raises `unshifted`. `unshifted` is low in every other case.
- R6: A constant right logical or right arithmetic shift by 0 behaves as a shift by 32.
- R7: A constant rotate by 0 is a one-bit rotate through carry. The operand is {`carry_in`, `rm_val[31:1]`} and the carry is `rm_val[0]`.
- R8: In register-shift form the amount is `rs_byte`. An amount of 0 passes `rm_val` through and keeps `carry_in`, for every shift type.
- R9: A left or right logical shift by exactly 32 gives 0, with carry `rm_val[0]` (left) or `rm_val[31]` (right). Amounts above 32 give 0 with carry 0.
- R10: A right arithmetic shift by 32 or more fills every bit with `rm_val[31]` and sets the carry to `rm_val[31]`.
- R11: A register rotate by a non-zero multiple of 32 leaves `rm_val` unchanged, with carry `rm_val[31]`. Other rotate amounts rotate by the amount modulo 32.
- R12: `extra_cycle` is high exactly for the register-shift form.
- R13: For amounts 1 to 31, the carry is the last bit shifted out. For a rotate, that is bit 31 of the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imm_form | input | 1 | Operand is a rotated immediate |
| op_field | input | 12 | Low twelve bits of the instruction |
| rm_val | input | 32 | Value of the shifted register |
| rs_byte | input | 8 | Low byte of the amount register |
| carry_in | input | 1 | Current carry flag |
| rm_idx | output | 4 | Index of the shifted register |
| rs_idx | output | 4 | Index of the amount register |
| operand | output | 32 | Registered second operand |
| carry_out | output | 1 | Registered shifter carry |
| unshifted | output | 1 | Registered: operand is Rm with no shift |
| extra_cycle | output | 1 | Registered: register-shift form needs one more cycle |

## Verification
The hardest cases to reach are the amounts that sit outside the constant field: exactly 32, just past 32, multiples of 32 for a rotate, and values near 255. Only the register form can reach them, and only through the low byte of the amount register. The directed tasks drive `rs_byte` to 32, 33, 36, 64, 200 and 255 with bit patterns in `rm_val` whose end bits differ, so that a wrong carry source shows up. A sweep of amounts 1 to 31 for all four shift types is compared against a bit-serial reference model.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } sh_type_e;

  typedef enum logic [2:0] {
    OP_PASS = 3'd0,
    OP_LSL  = 3'd1,
    OP_LSR  = 3'd2,
    OP_ASR  = 3'd3,
    OP_ROR  = 3'd4,
    OP_RRX  = 3'd5
  } sh_op_e;

  localparam int unsigned AMT_W = 8;
endpackage

// File: rtl/opsh_imm_rotate.sv
module opsh_imm_rotate #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic [ROT_W-1:0]  rot,
  input  logic              cin,
  output logic [DATA_W-1:0] val,
  output logic              cout
);
  localparam int RAMT_W = ROT_W + 1;

  logic [RAMT_W-1:0]   ramt;
  logic [DATA_W-1:0]   base;

  assign ramt = {rot, 1'b0};
  assign base = {{(DATA_W-IMM_W){1'b0}}, imm};
  assign val  = (base >> ramt) | (base << (RAMT_W'(DATA_W) - ramt));
  // Rotating by zero leaves the old carry in place
  assign cout = (rot != '0) ? val[DATA_W-1] : cin;
endmodule

// File: rtl/opsh_shift_decode.sv
module opsh_shift_decode
  import opsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SFT_W  = $clog2(DATA_W)
) (
  input  logic [1:0]       ty,
  input  logic [SFT_W-1:0] imm_amt,
  input  logic [AMT_W-1:0] reg_amt,
  input  logic             reg_form,
  output sh_op_e           op,
  output logic [AMT_W-1:0] amt,
  output logic             unshifted
);
  sh_op_e base_op;

  always_comb begin
    unique case (sh_type_e'(ty))
      SH_LSL:  base_op = OP_LSL;
      SH_LSR:  base_op = OP_LSR;
      SH_ASR:  base_op = OP_ASR;
      default: base_op = OP_ROR;
    endcase
  end

  always_comb begin
    op        = base_op;
    unshifted = 1'b0;
    amt       = reg_form ? reg_amt : {{(AMT_W-SFT_W){1'b0}}, imm_amt};
    if (reg_form) begin
      if (reg_amt == '0) op = OP_PASS;
    end else if (imm_amt == '0) begin
      // zero constant amounts are reinterpreted per shift type
      unique case (sh_type_e'(ty))
        SH_LSL: begin
          op        = OP_PASS;
          unshifted = 1'b1;
        end
        SH_LSR, SH_ASR: amt = AMT_W'(DATA_W);
        default:        op  = OP_RRX;
      endcase
    end
  end
endmodule

// File: rtl/opsh_barrel.sv
module opsh_barrel
  import opsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SFT_W  = $clog2(DATA_W)
) (
  input  sh_op_e            op,
  input  logic [AMT_W-1:0]  amt,
  input  logic [DATA_W-1:0] rm,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int SFT1_W = SFT_W + 1;

  logic [DATA_W:0]        lsl_w;
  logic [DATA_W:0]        lsr_w;
  logic signed [DATA_W:0] asr_w;
  logic [SFT_W-1:0]       rot;
  logic [DATA_W-1:0]      ror_res;

  // One guard bit beside the data captures the last bit shifted out
  assign lsl_w   = {1'b0, rm} << amt;
  assign lsr_w   = {rm, 1'b0} >> amt;
  assign asr_w   = $signed({rm, 1'b0}) >>> amt;
  assign rot     = amt[SFT_W-1:0];
  assign ror_res = (rm >> rot) | (rm << (SFT1_W'(DATA_W) - {1'b0, rot}));

  always_comb begin
    unique case (op)
      OP_LSL: begin
        res  = lsl_w[DATA_W-1:0];
        cout = lsl_w[DATA_W];
      end
      OP_LSR: begin
        res  = lsr_w[DATA_W:1];
        cout = lsr_w[0];
      end
      OP_ASR: begin
        res  = asr_w[DATA_W:1];
        cout = asr_w[0];
      end
      OP_ROR: begin
        res  = ror_res;
        cout = ror_res[DATA_W-1];
      end
      OP_RRX: begin
        res  = {cin, rm[DATA_W-1:1]};
        cout = rm[0];
      end
      default: begin
        res  = rm;
        cout = cin;
      end
    endcase
  end
endmodule

// File: rtl/opsh_operand_gen.sv
module opsh_operand_gen
  import opsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FLD_W  = 12,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              imm_form,
  input  logic [FLD_W-1:0]  op_field,
  input  logic [DATA_W-1:0] rm_val,
  input  logic [AMT_W-1:0]  rs_byte,
  input  logic              carry_in,
  output logic [IDX_W-1:0]  rm_idx,
  output logic [IDX_W-1:0]  rs_idx,
  output logic [DATA_W-1:0] operand,
  output logic              carry_out,
  output logic              unshifted,
  output logic              extra_cycle
);
  localparam int SFT_W   = $clog2(DATA_W);
  localparam int RSH_BIT = 4;

  logic              reg_form;
  sh_op_e            dec_op;
  logic [AMT_W-1:0]  dec_amt;
  logic              dec_unsh;
  logic [DATA_W-1:0] imm_val, sh_val;
  logic              imm_c, sh_c;

  assign rm_idx   = op_field[IDX_W-1:0];
  assign rs_idx   = op_field[FLD_W-1 -: IDX_W];
  assign reg_form = op_field[RSH_BIT];

  opsh_imm_rotate #(.DATA_W(DATA_W), .IMM_W(8), .ROT_W(4)) u_imm (
    .imm  (op_field[7:0]),
    .rot  (op_field[11:8]),
    .cin  (carry_in),
    .val  (imm_val),
    .cout (imm_c)
  );

  opsh_shift_decode #(.DATA_W(DATA_W), .SFT_W(SFT_W)) u_dec (
    .ty        (op_field[6:5]),
    .imm_amt   (op_field[11:7]),
    .reg_amt   (rs_byte),
    .reg_form  (reg_form),
    .op        (dec_op),
    .amt       (dec_amt),
    .unshifted (dec_unsh)
  );

  opsh_barrel #(.DATA_W(DATA_W), .SFT_W(SFT_W)) u_bsh (
    .op   (dec_op),
    .amt  (dec_amt),
    .rm   (rm_val),
    .cin  (carry_in),
    .res  (sh_val),
    .cout (sh_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      operand     <= '0;
      carry_out   <= 1'b0;
      unshifted   <= 1'b0;
      extra_cycle <= 1'b0;
    end else begin
      operand     <= imm_form ? imm_val : sh_val;
      carry_out   <= imm_form ? imm_c : sh_c;
      unshifted   <= !imm_form && dec_unsh;
      extra_cycle <= !imm_form && reg_form;
    end
  end
endmodule

// File: rtl/opsh_operand_gen_chk.sv
module opsh_operand_gen_chk #(
  parameter int DATA_W = 32,
  parameter int FLD_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              imm_form,
  input logic [FLD_W-1:0]  op_field,
  input logic [DATA_W-1:0] rm_val,
  input logic [7:0]        rs_byte,
  input logic              carry_in,
  input logic [DATA_W-1:0] operand,
  input logic              carry_out,
  input logic              unshifted,
  input logic              extra_cycle
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (operand == '0 && !carry_out && !unshifted && !extra_cycle));

  assert_rot_zero_keeps_carry_R3: assert property (@(posedge clk) disable iff (rst)
    (imm_form && op_field[11:8] == 4'd0) |=>
      (operand == DATA_W'($past(op_field[7:0])) && carry_out == $past(carry_in)));

  assert_lsl_zero_unshifted_R5: assert property (@(posedge clk) disable iff (rst)
    (!imm_form && !op_field[4] && op_field[6:5] == 2'b00 && op_field[11:7] == 5'd0) |=>
      (unshifted && operand == $past(rm_val) && carry_out == $past(carry_in)));

  assert_rrx_R7: assert property (@(posedge clk) disable iff (rst)
    (!imm_form && !op_field[4] && op_field[6:5] == 2'b11 && op_field[11:7] == 5'd0) |=>
      (operand == {$past(carry_in), $past(rm_val[DATA_W-1:1])} && carry_out == $past(rm_val[0])));

  assert_reg_zero_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (!imm_form && op_field[4] && rs_byte == 8'd0) |=>
      (operand == $past(rm_val) && carry_out == $past(carry_in)));

  assert_asr_fill_R10: assert property (@(posedge clk) disable iff (rst)
    (!imm_form && op_field[4] && op_field[6:5] == 2'b10 && rs_byte >= 8'd32) |=>
      (operand == {DATA_W{$past(rm_val[DATA_W-1])}}));

  assert_extra_excl_R12: assert property (@(posedge clk) disable iff (rst)
    extra_cycle |-> !unshifted);

  assert_extra_form_R12: assert property (@(posedge clk) disable iff (rst)
    (!imm_form && op_field[4]) |=> extra_cycle);
endmodule

bind opsh_operand_gen opsh_operand_gen_chk #(.DATA_W(DATA_W), .FLD_W(FLD_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .imm_form    (imm_form),
  .op_field    (op_field),
  .rm_val      (rm_val),
  .rs_byte     (rs_byte),
  .carry_in    (carry_in),
  .operand     (operand),
  .carry_out   (carry_out),
  .unshifted   (unshifted),
  .extra_cycle (extra_cycle)
);

// File: tb/sim_opsh_operand_gen.sv
module sim_opsh_operand_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imm_form = 1'b0;
  logic [11:0] op_field = '0;
  logic [31:0] rm_val = '0;
  logic [7:0]  rs_byte = '0;
  logic        carry_in = 1'b0;
  logic [3:0]  rm_idx, rs_idx;
  logic [31:0] operand;
  logic        carry_out, unshifted, extra_cycle;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  opsh_operand_gen u0 (
    .clk(clk), .rst(rst), .imm_form(imm_form), .op_field(op_field),
    .rm_val(rm_val), .rs_byte(rs_byte), .carry_in(carry_in),
    .rm_idx(rm_idx), .rs_idx(rs_idx), .operand(operand),
    .carry_out(carry_out), .unshifted(unshifted), .extra_cycle(extra_cycle)
  );

  // Bit-serial reference built from the requirements
  function automatic void ref_model(input logic imf, input logic [11:0] f,
                                    input logic [31:0] rm, input logic [7:0] rs,
                                    input logic ci, output logic [31:0] r,
                                    output logic c, output logic u, output logic x);
    int n;
    logic rrx;
    r = rm; c = ci; u = 1'b0; x = !imf && f[4]; rrx = 1'b0;
    if (imf) begin
      r = {24'b0, f[7:0]};
      n = 2 * int'(f[11:8]);
      for (int i = 0; i < n; i++) r = {r[0], r[31:1]};
      if (n != 0) c = r[31];
    end else begin
      n = f[4] ? int'(rs) : int'(f[11:7]);
      if (!f[4] && n == 0) begin
        case (f[6:5])
          2'b00: u = 1'b1;
          2'b01, 2'b10: n = 32;
          default: begin
            rrx = 1'b1;
            c = rm[0];
            r = {ci, rm[31:1]};
          end
        endcase
      end
      if (!rrx) begin
        for (int i = 0; i < n; i++) begin
          case (f[6:5])
            2'b00: begin c = r[31]; r = r << 1; end
            2'b01: begin c = r[0]; r = r >> 1; end
            2'b10: begin c = r[0]; r = {r[31], r[31:1]}; end
            default: begin c = r[0]; r = {r[0], r[31:1]}; end
          endcase
        end
      end
    end
  endfunction

  task automatic check(input string tag, input logic [34:0] act, input logic [34:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual op=%08h c=%0b u=%0b x=%0b expected op=%08h c=%0b u=%0b x=%0b",
               tag, act[34:3], act[2], act[1], act[0], exp[34:3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic apply(input string tag, input logic imf, input logic [11:0] f,
                       input logic [31:0] rm, input logic [7:0] rs, input logic ci);
    logic [31:0] er;
    logic ec, eu, ex;
    imm_form = imf; op_field = f; rm_val = rm; rs_byte = rs; carry_in = ci;
    ref_model(imf, f, rm, rs, ci, er, ec, eu, ex);
    @(negedge clk);
    check(tag, {operand, carry_out, unshifted, extra_cycle}, {er, ec, eu, ex});
  endtask

  function automatic logic [11:0] cfld(input logic [4:0] a, input logic [1:0] t);
    return {a, t, 1'b0, 4'h3};
  endfunction

  function automatic logic [11:0] rfld(input logic [1:0] t);
    return {4'h9, 1'b0, t, 1'b1, 4'h5};
  endfunction

  task automatic t_reset;
    // R1: outputs zero during reset
    rst = 1'b1;
    imm_form = 1'b1; op_field = 12'h0FF; carry_in = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 reset", {operand, carry_out, unshifted, extra_cycle}, 35'd0);
    rst = 1'b0;
  endtask

  task automatic t_rot_imm;
    apply("R3 rot0 keeps carry", 1'b1, 12'h0FF, 32'h0, 8'h0, 1'b1);
    apply("R3 rot2", 1'b1, 12'h1FF, 32'h0, 8'h0, 1'b0);
    apply("R3 rot30", 1'b1, 12'hF01, 32'h0, 8'h0, 1'b1);
    apply("R3 rot8 carry set", 1'b1, 12'h480, 32'h0, 8'h0, 1'b0);
    apply("R2 immediate ignores rm", 1'b1, 12'h2A5, 32'hFFFF_FFFF, 8'h20, 1'b0);
  endtask

  task automatic t_const_shift;
    // R4: index outputs follow the field combinationally
    op_field = 12'hA57; #1;
    n_cmp++;
    if (rm_idx !== 4'h7 || rs_idx !== 4'hA) begin
      n_bad++;
      $display("FAIL R4 idx: actual rm=%h rs=%h expected rm=7 rs=a", rm_idx, rs_idx);
    end
    apply("R13 lsl4", 1'b0, cfld(5'd4, 2'b00), 32'hF000_000F, 8'h0, 1'b0);
    apply("R13 lsr1", 1'b0, cfld(5'd1, 2'b01), 32'h8000_0001, 8'h0, 1'b0);
    apply("R13 asr31", 1'b0, cfld(5'd31, 2'b10), 32'hC000_0000, 8'h0, 1'b0);
    apply("R13 ror8", 1'b0, cfld(5'd8, 2'b11), 32'h1234_5680, 8'h0, 1'b0);
    apply("R5 lsl0 c1", 1'b0, cfld(5'd0, 2'b00), 32'hDEAD_BEEF, 8'h0, 1'b1);
    apply("R5 lsl0 c0", 1'b0, cfld(5'd0, 2'b00), 32'h8000_0001, 8'h0, 1'b0);
    apply("R6 lsr0 is 32", 1'b0, cfld(5'd0, 2'b01), 32'h8000_0000, 8'h0, 1'b0);
    apply("R6 asr0 is 32", 1'b0, cfld(5'd0, 2'b10), 32'h8765_4321, 8'h0, 1'b0);
    apply("R7 rrx c1", 1'b0, cfld(5'd0, 2'b11), 32'h0000_0003, 8'h0, 1'b1);
    apply("R7 rrx c0", 1'b0, cfld(5'd0, 2'b11), 32'h8000_0000, 8'h0, 1'b0);
  endtask

  task automatic t_reg_shift;
    for (int t = 0; t < 4; t++)
      apply("R8 reg amount 0", 1'b0, rfld(2'(t)), 32'hA5A5_0F0F, 8'd0, 1'b1);
    apply("R9 lsl32", 1'b0, rfld(2'b00), 32'h0000_0001, 8'd32, 1'b0);
    apply("R9 lsl33", 1'b0, rfld(2'b00), 32'hFFFF_FFFF, 8'd33, 1'b1);
    apply("R9 lsr32", 1'b0, rfld(2'b01), 32'h8000_0000, 8'd32, 1'b0);
    apply("R9 lsr200", 1'b0, rfld(2'b01), 32'hFFFF_FFFF, 8'd200, 1'b1);
    apply("R10 asr32 neg", 1'b0, rfld(2'b10), 32'h8000_0001, 8'd32, 1'b0);
    apply("R10 asr255 neg", 1'b0, rfld(2'b10), 32'hF000_0000, 8'd255, 1'b0);
    apply("R10 asr40 pos", 1'b0, rfld(2'b10), 32'h7FFF_FFFF, 8'd40, 1'b1);
    apply("R11 ror32", 1'b0, rfld(2'b11), 32'h8000_0002, 8'd32, 1'b0);
    apply("R11 ror64", 1'b0, rfld(2'b11), 32'h1234_5678, 8'd64, 1'b1);
    apply("R11 ror36", 1'b0, rfld(2'b11), 32'h0000_00F1, 8'd36, 1'b0);
  endtask

  task automatic t_sweep;
    // R13 and R12: amounts 1..31 for each type, register form
    for (int t = 0; t < 4; t++)
      for (int a = 1; a < 32; a++)
        apply("R13 sweep", 1'b0, rfld(2'(t)), 32'h9E37_79B9 ^ (32'h1 << a), 8'(a), a[0]);
    apply("R12 const form no extra", 1'b0, cfld(5'd3, 2'b01), 32'h1, 8'd9, 1'b0);
  endtask

  task automatic t_mid_reset;
    imm_form = 1'b0; op_field = rfld(2'b00); rm_val = 32'h1; rs_byte = 8'd3;
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset midstream", {operand, carry_out, unshifted, extra_cycle}, 35'd0);
    rst = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_rot_imm();
    t_const_shift();
    t_reg_shift();
    t_sweep();
    t_mid_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule